// File: doc/BRIEF.md
# Processor halt and stop controller

This block sits beside the issue stage of a small processor core and decides whether the core runs, waits or freezes. A halt decode moves it into a waiting state: instruction issue stops, but the core clock keeps running so that a wake event can be seen. A stop decode moves it into a frozen state: the core clock enable drops, and nothing except reset has any effect from then on.

When the block is halted, it takes a wake from four sources. These are a rising edge on the non-maskable interrupt line, a debug event, a soft-init request, and any pending maskable interrupt line. The maskable interrupt counts only if interrupts were enabled at the moment the halt was decoded. On a wake, the block returns to running and reports a one-cycle wake strobe with a two-bit cause code. Vectoring to a handler is left to the core. A handler that returns onto the halt instruction simply produces another halt decode, and the block halts again.

Top module: `core_pause_ctrl`

## Requirements
- R1: An active-low reset (`rst_n`) acts at once and overrides every other input. During and after reset `run_en`=1, `clk_en`=1, `state_o`=2'b00 (running) and `wake_vld`=0.
- R2: A halt decode while running gives `state_o`=2'b01, `run_en`=0 and `clk_en`=1 in the following cycle.
- R3: A stop decode while running gives `state_o`=2'b10, `run_en`=0 and `clk_en`=0 in the following cycle. A stop decode wins over a halt decode in the same cycle.
- R4: In the stop state every input except `rst_n` is ignored, and the outputs stay at their stop values until reset.
- R5: If `irq_en` was 1 in the cycle of the halt decode, any set bit of `irq` wakes the core with `wake_cause`=2'b00.
- R6: If `irq_en` was 0 in the cycle of the halt decode, pending `irq` bits never wake the core, whatever `irq_en` does while halted.
- R7: A rising edge of `nmi` wakes a halted core whatever the interrupt mask, with `wake_cause`=2'b01. An `nmi` held high gives only one wake.
- R8: A debug event wakes with `wake_cause`=2'b10. A soft-init request wakes with `wake_cause`=2'b11.
- R9: When several wake sources are present in one cycle, the cause reported is the first present in this order: `nmi` edge, debug, init, `irq`.
- R10: A wake event gives `wake_vld`=1 for exactly one cycle, and `run_en`=1 and `state_o`=2'b00 in the cycle after the event.
- R11: After a wake, a new halt decode halts the core again, and a later fresh `nmi` edge wakes it again.
- R12: While halted, halt and stop decodes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_dec | input | 1 | Halt instruction decoded this cycle |
| stop_dec | input | 1 | Stop instruction decoded this cycle |
| irq | input | N_IRQ | Maskable interrupt request lines |
| irq_en | input | 1 | Maskable interrupt enable flag of the core |
| nmi | input | 1 | Non-maskable interrupt request level |
| dbg_evt | input | 1 | Debug event |
| init_req | input | 1 | Soft-init request |
| run_en | output | 1 | Instruction issue enable for the core |
| clk_en | output | 1 | Core clock enable |
| state_o | output | 2 | 00 running, 01 halted, 10 stopped |
| wake_vld | output | 1 | One-cycle wake strobe |
| wake_cause | output | 2 | 00 irq, 01 nmi, 10 debug, 11 init; valid with wake_vld |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it. This holds for state entry, the enables, the wake strobe and its cause. With the default of zero `nmi` synchronizer stages, a new `nmi` edge is also seen at the next edge. The bench drives each input vector just after a falling edge and lets one rising edge pass. At the following falling edge it compares all outputs against a model it updates once per vector. The model tracks the captured mask and the last `nmi` level, so held-high `nmi` lines and interrupt-enable changes during a halt are predicted exactly.

// File: rtl/pause_pkg.sv
package pause_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'b00,
      PS_HALT = 2'b01,
      PS_STOP = 2'b10
   } pause_state_e;

   typedef enum logic [1:0] {
      WC_IRQ  = 2'b00,
      WC_NMI  = 2'b01,
      WC_DBG  = 2'b10,
      WC_INIT = 2'b11
   } wake_cause_e;

endpackage

// File: rtl/pause_edge_det.sv
module pause_edge_det #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic level;
   logic level_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else if (SYNC_STAGES == 1) sync_q <= din;
            else sync_q <= {sync_q[SYNC_STAGES-2:0], din};
         end
         assign level = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
endmodule

// File: rtl/pause_wake_arb.sv
module pause_wake_arb
   import pause_pkg::*;
#(
   parameter int N_IRQ = 4
) (
   input  logic [N_IRQ-1:0] irq,
   input  logic             irq_masked,
   input  logic             nmi_rise,
   input  logic             dbg_evt,
   input  logic             init_req,
   output logic             wake,
   output wake_cause_e      cause
);
   logic irq_live;

   assign irq_live = (|irq) & ~irq_masked;

   always_comb begin
      wake  = 1'b1;
      cause = WC_IRQ;
      if (nmi_rise)      cause = WC_NMI;
      else if (dbg_evt)  cause = WC_DBG;
      else if (init_req) cause = WC_INIT;
      else if (irq_live) cause = WC_IRQ;
      else               wake  = 1'b0;
   end
endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
   import pause_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         halt_dec,
   input  logic         stop_dec,
   input  logic         irq_en,
   input  logic         wake,
   input  wake_cause_e  cause_in,
   output pause_state_e state,
   output logic         irq_masked,
   output logic         wake_vld,
   output wake_cause_e  wake_cause
);
   pause_state_e state_nx;
   logic         masked_nx;
   logic         vld_nx;

   always_comb begin
      state_nx  = state;
      masked_nx = irq_masked;
      vld_nx    = 1'b0;
      unique case (state)
         PS_RUN: begin
            if (stop_dec) begin
               state_nx = PS_STOP;
            end else if (halt_dec) begin
               state_nx  = PS_HALT;
               masked_nx = ~irq_en;
            end
         end
         PS_HALT: begin
            if (wake) begin
               state_nx = PS_RUN;
               vld_nx   = 1'b1;
            end
         end
         default: state_nx = PS_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PS_RUN;
         irq_masked <= 1'b0;
         wake_vld   <= 1'b0;
         wake_cause <= WC_IRQ;
      end else begin
         state      <= state_nx;
         irq_masked <= masked_nx;
         wake_vld   <= vld_nx;
         if (vld_nx) wake_cause <= cause_in;
      end
   end
endmodule

// File: rtl/core_pause_ctrl.sv
module core_pause_ctrl
   import pause_pkg::*;
#(
   parameter int N_IRQ           = 4,
   parameter int NMI_SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_dec,
   input  logic             stop_dec,
   input  logic [N_IRQ-1:0] irq,
   input  logic             irq_en,
   input  logic             nmi,
   input  logic             dbg_evt,
   input  logic             init_req,
   output logic             run_en,
   output logic             clk_en,
   output logic [1:0]       state_o,
   output logic             wake_vld,
   output logic [1:0]       wake_cause
);
   localparam int MAX_IRQ  = 64;
   localparam int MAX_SYNC = 4;

   generate
      if (N_IRQ < 1 || N_IRQ > MAX_IRQ) begin : g_bad_irq
         $error("core_pause_ctrl: N_IRQ out of range");
      end
      if (NMI_SYNC_STAGES < 0 || NMI_SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("core_pause_ctrl: NMI_SYNC_STAGES out of range");
      end
   endgenerate

   logic         nmi_rise;
   logic         irq_masked;
   logic         wake;
   wake_cause_e  cause;
   pause_state_e state;
   wake_cause_e  cause_q;

   pause_edge_det #(.SYNC_STAGES(NMI_SYNC_STAGES)) u_nmi_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (nmi),
      .rise  (nmi_rise)
   );

   pause_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
      .irq        (irq),
      .irq_masked (irq_masked),
      .nmi_rise   (nmi_rise),
      .dbg_evt    (dbg_evt),
      .init_req   (init_req),
      .wake       (wake),
      .cause      (cause)
   );

   pause_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_dec   (halt_dec),
      .stop_dec   (stop_dec),
      .irq_en     (irq_en),
      .wake       (wake),
      .cause_in   (cause),
      .state      (state),
      .irq_masked (irq_masked),
      .wake_vld   (wake_vld),
      .wake_cause (cause_q)
   );

   assign run_en     = (state == PS_RUN);
   assign clk_en     = (state != PS_STOP);
   assign state_o    = state;
   assign wake_cause = cause_q;
endmodule

// File: rtl/core_pause_ctrl_chk.sv
module core_pause_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       halt_dec,
   input logic       stop_dec,
   input logic       run_en,
   input logic       clk_en,
   input logic [1:0] state_o,
   input logic       wake_vld
);
   p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && halt_dec && !stop_dec) |=> (state_o == 2'b01 && !run_en && clk_en));

   p_stop_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b00 && stop_dec) |=> (state_o == 2'b10 && !run_en && !clk_en));

   p_stop_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b10) |=> (state_o == 2'b10 && !clk_en));

   p_wake_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_vld |=> !wake_vld);

   p_wake_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b01 && !wake_vld) |=> (wake_vld == run_en));

   p_halt_ignores_dec_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'b01) |=> (state_o != 2'b10));
endmodule

bind core_pause_ctrl core_pause_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .halt_dec (halt_dec),
   .stop_dec (stop_dec),
   .run_en   (run_en),
   .clk_en   (clk_en),
   .state_o  (state_o),
   .wake_vld (wake_vld)
);

// File: tb/tb_core_pause_ctrl.sv
module tb_core_pause_ctrl;
   localparam int NI = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          halt_dec = 1'b0, stop_dec = 1'b0;
   logic [NI-1:0] irq = '0;
   logic          irq_en = 1'b0, nmi = 1'b0, dbg_evt = 1'b0, init_req = 1'b0;
   logic          run_en, clk_en, wake_vld;
   logic [1:0]    state_o, wake_cause;

   int vectors = 0;
   int fails   = 0;

   // bench model
   logic [1:0] m_st = 2'b00;
   logic       m_mask = 1'b0, m_nq = 1'b0, m_vld = 1'b0;
   logic [1:0] m_cause = 2'b00;

   always #5 clk = ~clk;

   core_pause_ctrl #(.N_IRQ(NI)) dut (
      .clk(clk), .rst_n(rst_n), .halt_dec(halt_dec), .stop_dec(stop_dec),
      .irq(irq), .irq_en(irq_en), .nmi(nmi), .dbg_evt(dbg_evt), .init_req(init_req),
      .run_en(run_en), .clk_en(clk_en), .state_o(state_o),
      .wake_vld(wake_vld), .wake_cause(wake_cause)
   );

   function automatic string pick_tag(input logic r, h, s, input logic [NI-1:0] iq,
                                      input logic n, d, it);
      logic e;
      int   k;
      e = n && !m_nq;
      k = int'(e) + int'(d) + int'(it) + int'((|iq) && !m_mask);
      if (!r) return "R1";
      if (m_st == 2'b10) return "R4";
      if (m_st == 2'b00) return s ? "R3" : (h ? "R2" : "R10");
      if (k > 1) return "R9";
      if (e) return "R7";
      if (d || it) return "R8";
      if ((|iq) && !m_mask) return "R5";
      if ((|iq) && m_mask) return "R6";
      if (h || s) return "R12";
      return "R10";
   endfunction

   task automatic model_step(input logic r, h, s, input logic [NI-1:0] iq,
                             input logic ie, n, d, it);
      logic e;
      if (!r) begin
         m_st = 2'b00; m_mask = 1'b0; m_nq = 1'b0; m_vld = 1'b0; m_cause = 2'b00;
         return;
      end
      e = n && !m_nq;
      m_nq  = n;
      m_vld = 1'b0;
      case (m_st)
         2'b00: if (s) m_st = 2'b10;
                else if (h) begin m_st = 2'b01; m_mask = !ie; end
         2'b01: begin
            m_vld = 1'b1;
            if (e)                       m_cause = 2'b01;
            else if (d)                  m_cause = 2'b10;
            else if (it)                 m_cause = 2'b11;
            else if ((|iq) && !m_mask)   m_cause = 2'b00;
            else                         m_vld = 1'b0;
            if (m_vld) m_st = 2'b00;
         end
         default: ;
      endcase
   endtask

   task automatic apply(input logic r, h, s, input logic [NI-1:0] iq,
                        input logic ie, n, d, it);
      string tag;
      logic  ok;
      logic  er, ec;
      tag = pick_tag(r, h, s, iq, n, d, it);
      rst_n = r; halt_dec = h; stop_dec = s; irq = iq;
      irq_en = ie; nmi = n; dbg_evt = d; init_req = it;
      model_step(r, h, s, iq, ie, n, d, it);
      @(posedge clk);
      @(negedge clk);
      er = (m_st == 2'b00);
      ec = (m_st != 2'b10);
      ok = (run_en === er) && (clk_en === ec) && (state_o === m_st) &&
           (wake_vld === m_vld) && (!m_vld || wake_cause === m_cause);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got run=%b clk=%b st=%b vld=%b cause=%b, expected run=%b clk=%b st=%b vld=%b cause=%b",
                  tag, run_en, clk_en, state_o, wake_vld, wake_cause,
                  er, ec, m_st, m_vld, m_cause);
      end
   endtask

   // shorthands keep nmi at its current level
   task automatic idle(); apply(1, 0, 0, '0, irq_en, nmi, 0, 0); endtask
   task automatic halt(input logic ie); apply(1, 1, 0, '0, ie, nmi, 0, 0); endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL R1: watchdog expired, got running bench, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      // R1 reset state
      apply(0, 0, 0, '0, 0, 0, 0, 0);
      apply(0, 1, 1, '1, 1, 1, 1, 1);
      idle();
      // R2 halt, R5 irq wakes when enabled at entry
      halt(1); idle();
      apply(1, 0, 0, 4'b0100, 1, 0, 0, 0);
      idle();
      // R6 masked at entry: irq ignored even when irq_en rises
      halt(0);
      apply(1, 0, 0, 4'b0001, 0, 0, 0, 0);
      apply(1, 0, 0, 4'b1111, 1, 0, 0, 0);
      apply(1, 0, 0, 4'b1000, 1, 0, 0, 0);
      // R8 debug wake
      apply(1, 0, 0, 4'b1000, 1, 0, 1, 0);
      // R8 init wake
      halt(1); apply(1, 0, 0, '0, 1, 0, 0, 1);
      // R7 nmi wakes while masked, R11 re-halt with nmi held high
      halt(0);
      apply(1, 0, 0, 4'b0010, 0, 1, 0, 0);
      halt(0);
      apply(1, 0, 0, '0, 0, 1, 0, 0);
      apply(1, 0, 0, '0, 0, 1, 0, 0);
      apply(1, 0, 0, '0, 0, 0, 0, 0);
      apply(1, 0, 0, '0, 0, 1, 0, 0);   // R11 fresh edge wakes
      apply(1, 0, 0, '0, 0, 0, 0, 0);
      // R9 priority cases
      halt(1); apply(1, 0, 0, '1, 1, 1, 1, 1);
      apply(1, 0, 0, '0, 1, 0, 0, 0);
      halt(1); apply(1, 0, 0, '1, 1, 0, 1, 1);
      halt(1); apply(1, 0, 0, '1, 1, 0, 0, 1);
      // R12 decodes ignored while halted
      halt(1);
      apply(1, 1, 0, '0, 1, 0, 0, 0);
      apply(1, 0, 1, '0, 1, 0, 0, 0);
      apply(1, 1, 1, '0, 1, 0, 0, 0);
      apply(1, 0, 0, '0, 1, 0, 1, 0);
      // R3 stop wins over halt, R4 everything ignored
      apply(1, 1, 1, '0, 1, 0, 0, 0);
      apply(1, 1, 0, '1, 1, 1, 1, 1);
      apply(1, 0, 1, '1, 1, 0, 1, 1);
      apply(1, 0, 0, '1, 1, 1, 0, 0);
      apply(0, 0, 0, '0, 0, 0, 0, 0);   // R1 only reset leaves stop
      idle();

      for (int i = 0; i < 4000; i++) begin
         logic r, h, s, ie, n, d, it;
         logic [NI-1:0] iq;
         r  = !(($urandom % 60) == 0) && !(m_st == 2'b10 && ($urandom % 8) == 0);
         h  = ($urandom % 6) == 0;
         s  = ($urandom % 40) == 0;
         iq = (($urandom % 4) == 0) ? NI'($urandom) : '0;
         ie = ($urandom % 2) == 0;
         n  = (($urandom % 7) == 0) ? !nmi : nmi;
         d  = ($urandom % 20) == 0;
         it = ($urandom % 25) == 0;
         apply(r, h, s, iq, ie, n, d, it);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule